// File: doc/BRIEF.md
# Single-Wire Slave Device Selection Layer

This block is the addressing stage of a single-wire bus slave. It sits between a bit-level slot engine and the function layer of the device. After every bus reset it collects one eight-bit command from the master. Depending on the command, it sends its 64-bit identity, compares an identity the master sends, takes part in a bitwise tree search, or skips selection. Once selection succeeds it raises `selected_o` so that the function layer can take over.

The identity is built from three parts. The family code sits in the low byte and is a parameter. The 48-bit serial number and the 8-bit check byte come in through ports; the check byte is computed elsewhere. The block keeps a reselect flag so that a device that was individually addressed earlier can be picked again without sending its identity. It also keeps a high-speed flag, which the slot engine reads through `od_o` to choose its timing.

The slot engine pulses `slot_i` once for each completed time slot and gives the sampled line level on `slot_val_i`. Before each slot the block states on `tx_en_o` whether it will drive the slot and, if so, which value on `tx_bit_o`. A slot in which the block does not drive counts as a bit written by the master.

Top module: `romsel_core`

## Requirements
- R1: After power-up reset, `selected_o`, `od_o` and `tx_en_o` are 0. Slots that arrive before the first bus reset are ignored.
- R2: After a bus reset, the next eight undriven slots form the command byte, least significant bit first.
- R3: Command 33h makes the next 64 slots driven slots. Slot i carries bit i of the identity {check byte, serial, family}, and the default family code 3Ah comes first. After the 64th slot the device is selected.
- R4: Command 55h compares the next 64 written bits with the identity. A full match selects the device and sets the reselect flag. Any mismatch leaves the device unselected and silent until the next bus reset.
- R5: Command F0h runs 64 triplets of slots. The first slot of each triplet drives the identity bit, the second drives its complement, and the third reads the master's bit. If the master's bit differs, the device drops out until the next bus reset. If all 64 bits agree, the device is selected and the reselect flag is set.
- R6: Command CCh selects the device right after the command byte. While the device is selected it never drives a slot.
- R7: Command A5h selects the device only if the reselect flag is 1. Otherwise the device waits, unselected, for the next bus reset.
- R8: Commands 33h, 55h, F0h, CCh, 3Ch and 69h clear the reselect flag.
- R9: Commands 3Ch and 69h set `od_o` to 1 when the command byte completes. A bus reset with `long_reset_i` low keeps `od_o` as it is. Only a bus reset with `long_reset_i` high clears it.
- R10: Any other command byte leaves the device unselected and silent until the next bus reset.
- R11: A bus reset at any point ends the command in progress, deselects the device and restarts command collection. A bus reset takes priority over a slot in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| serial_i | input | 48 | Serial number part of the identity |
| crc_i | input | 8 | Check byte part of the identity |
| bus_reset_i | input | 1 | One-cycle pulse: a bus reset and presence have completed |
| long_reset_i | input | 1 | Qualifies `bus_reset_i` as a long reset that restores normal speed |
| slot_i | input | 1 | One-cycle pulse: a time slot has completed |
| slot_val_i | input | 1 | Line level sampled in the slot |
| tx_en_o | output | 1 | The block drives the next slot |
| tx_bit_o | output | 1 | Value driven in the next slot |
| selected_o | output | 1 | Device is selected; the function layer is active |
| od_o | output | 1 | High-speed flag |

## Verification
The bench targets the paths where the device must fall silent. These are a match that fails on a late bit, and a search in which the master picks the other branch. A design that got these wrong would keep driving the line or would go on to select itself. The reselect flag is tested in both directions, set by a match or a search and then cleared by a later skip. A wrong design would answer a reselect it should refuse, or refuse one it should answer. The bench also checks that the high-speed flag survives a short reset and clears on a long one, and that a reset in the middle of an identity stream drops back to command collection instead of carrying on with the old stream.

// File: rtl/romsel_pkg.sv
package romsel_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_READ,
        ST_MATCH,
        ST_SRCH,
        ST_SEL,
        ST_WAIT
    } romsel_st_e;

    localparam logic [7:0] OP_READ_ID   = 8'h33;
    localparam logic [7:0] OP_MATCH_ID  = 8'h55;
    localparam logic [7:0] OP_SEARCH    = 8'hF0;
    localparam logic [7:0] OP_SKIP      = 8'hCC;
    localparam logic [7:0] OP_RESELECT  = 8'hA5;
    localparam logic [7:0] OP_FAST_SKIP = 8'h3C;
    localparam logic [7:0] OP_FAST_MTCH = 8'h69;

endpackage

// File: rtl/romsel_cmd_rx.sv
module romsel_cmd_rx #(
    parameter int CMD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic             bit_i,
    output logic [CMD_W-1:0] byte_o,
    output logic             last_o
);
    localparam int CNT_W = $clog2(CMD_W);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CMD_W-2:0] shr;
    } rx_s;

    rx_s rx_q, rx_d;

    assign byte_o = {bit_i, rx_q.shr};
    assign last_o = en_i && (rx_q.cnt == CNT_W'(CMD_W - 1));

    always_comb begin
        rx_d = rx_q;
        if (clr_i) begin
            rx_d = '0;
        end else if (en_i) begin
            rx_d.shr = byte_o[CMD_W-1:1];
            rx_d.cnt = last_o ? '0 : rx_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

endmodule

// File: rtl/romsel_id_pick.sv
module romsel_id_pick #(
    parameter int              FAM_W       = 8,
    parameter int              SER_W       = 48,
    parameter int              CRC_W       = 8,
    parameter logic [FAM_W-1:0] FAMILY_CODE = 8'h3A,
    localparam int             ID_W        = FAM_W + SER_W + CRC_W,
    localparam int             IDX_W       = $clog2(ID_W)
) (
    input  logic [SER_W-1:0] serial_i,
    input  logic [CRC_W-1:0] crc_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic             bit_o
);
    logic [ID_W-1:0] id_w;

    assign id_w  = {crc_i, serial_i, FAMILY_CODE};
    assign bit_o = id_w[idx_i];

endmodule

// File: rtl/romsel_core.sv
module romsel_core
    import romsel_pkg::*;
#(
    parameter int               FAM_W       = 8,
    parameter int               SER_W       = 48,
    parameter int               CRC_W       = 8,
    parameter logic [FAM_W-1:0] FAMILY_CODE = 8'h3A
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SER_W-1:0] serial_i,
    input  logic [CRC_W-1:0] crc_i,
    input  logic             bus_reset_i,
    input  logic             long_reset_i,
    input  logic             slot_i,
    input  logic             slot_val_i,
    output logic             tx_en_o,
    output logic             tx_bit_o,
    output logic             selected_o,
    output logic             od_o
);
    localparam int CMD_W    = 8;
    localparam int ID_W     = FAM_W + SER_W + CRC_W;
    localparam int IDX_W    = $clog2(ID_W);
    localparam int LAST_IDX = ID_W - 1;

    typedef struct packed {
        romsel_st_e       st;
        logic [IDX_W-1:0] idx;
        logic [1:0]       ph;
        logic             rc;
        logic             od;
    } core_s;

    core_s q, d;

    logic             cmd_en;
    logic [CMD_W-1:0] cmd_byte;
    logic             cmd_last;
    logic             id_bit;
    logic             idx_last;

    assign cmd_en   = slot_i && !bus_reset_i && (q.st == ST_CMD);
    assign idx_last = (q.idx == IDX_W'(LAST_IDX));

    romsel_cmd_rx #(
        .CMD_W (CMD_W)
    ) u_cmd_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (bus_reset_i),
        .en_i   (cmd_en),
        .bit_i  (slot_val_i),
        .byte_o (cmd_byte),
        .last_o (cmd_last)
    );

    romsel_id_pick #(
        .FAM_W       (FAM_W),
        .SER_W       (SER_W),
        .CRC_W       (CRC_W),
        .FAMILY_CODE (FAMILY_CODE)
    ) u_id_pick (
        .serial_i (serial_i),
        .crc_i    (crc_i),
        .idx_i    (q.idx),
        .bit_o    (id_bit)
    );

    // Next-state computation
    always_comb begin
        d = q;
        if (bus_reset_i) begin
            d.st  = ST_CMD;
            d.idx = '0;
            d.ph  = 2'd0;
            if (long_reset_i) d.od = 1'b0;
        end else if (slot_i) begin
            unique case (q.st)
                ST_CMD: begin
                    if (cmd_last) begin
                        d.idx = '0;
                        d.ph  = 2'd0;
                        case (cmd_byte)
                            OP_READ_ID:   begin d.rc = 1'b0; d.st = ST_READ;  end
                            OP_MATCH_ID:  begin d.rc = 1'b0; d.st = ST_MATCH; end
                            OP_SEARCH:    begin d.rc = 1'b0; d.st = ST_SRCH;  end
                            OP_SKIP:      begin d.rc = 1'b0; d.st = ST_SEL;   end
                            OP_RESELECT:  d.st = q.rc ? ST_SEL : ST_WAIT;
                            OP_FAST_SKIP: begin d.rc = 1'b0; d.od = 1'b1; d.st = ST_SEL;   end
                            OP_FAST_MTCH: begin d.rc = 1'b0; d.od = 1'b1; d.st = ST_MATCH; end
                            default:      d.st = ST_WAIT;
                        endcase
                    end
                end
                ST_READ: begin
                    if (idx_last) d.st = ST_SEL;
                    else          d.idx = q.idx + IDX_W'(1);
                end
                ST_MATCH: begin
                    if (slot_val_i != id_bit) begin
                        d.st = ST_WAIT;
                    end else if (idx_last) begin
                        d.rc = 1'b1;
                        d.st = ST_SEL;
                    end else begin
                        d.idx = q.idx + IDX_W'(1);
                    end
                end
                ST_SRCH: begin
                    if (q.ph != 2'd2) begin
                        d.ph = q.ph + 2'd1;
                    end else if (slot_val_i != id_bit) begin
                        d.st = ST_WAIT;
                    end else if (idx_last) begin
                        d.rc = 1'b1;
                        d.st = ST_SEL;
                    end else begin
                        d.idx = q.idx + IDX_W'(1);
                        d.ph  = 2'd0;
                    end
                end
                default: d = q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    // Outputs from registered state
    always_comb begin
        tx_en_o  = 1'b0;
        tx_bit_o = 1'b1;
        if (q.st == ST_READ) begin
            tx_en_o  = 1'b1;
            tx_bit_o = id_bit;
        end else if (q.st == ST_SRCH && q.ph != 2'd2) begin
            tx_en_o  = 1'b1;
            tx_bit_o = (q.ph == 2'd0) ? id_bit : ~id_bit;
        end
    end

    assign selected_o = (q.st == ST_SEL);
    assign od_o       = q.od;

endmodule

// File: rtl/romsel_core_chk.sv
module romsel_core_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_reset_i,
    input logic long_reset_i,
    input logic slot_i,
    input logic tx_en_o,
    input logic tx_bit_o,
    input logic selected_o,
    input logic od_o
);
    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           seen_q <= 1'b0;
        else if (bus_reset_i) seen_q <= 1'b1;
    end

    // R1: quiet until the first bus reset
    p_quiet_before_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> (!selected_o && !tx_en_o && !od_o));

    // R11: a bus reset deselects and silences
    p_abort_on_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset_i |=> (!selected_o && !tx_en_o));

    // R9: high-speed flag rises only on a completed slot
    p_od_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(od_o) |-> ($past(slot_i) && !$past(bus_reset_i)));

    // R9: high-speed flag falls only on a long reset
    p_od_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(od_o) |-> $past(bus_reset_i && long_reset_i));

    // R6: a selected device never drives a slot
    p_sel_no_tx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        selected_o |-> !tx_en_o);

    // R3: outputs hold between slots
    p_hold_between_slots_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot_i && !bus_reset_i) |=> ($stable(tx_en_o) && $stable(tx_bit_o) && $stable(selected_o)));

    // R4: selection only completes on a slot
    p_sel_on_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(selected_o) |-> $past(slot_i));

endmodule

bind romsel_core romsel_core_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_reset_i  (bus_reset_i),
    .long_reset_i (long_reset_i),
    .slot_i       (slot_i),
    .tx_en_o      (tx_en_o),
    .tx_bit_o     (tx_bit_o),
    .selected_o   (selected_o),
    .od_o         (od_o)
);

// File: tb/romsel_core_tb.sv
module romsel_core_tb;
    localparam logic [47:0] SER = 48'h5D21_F07C_9E13;
    localparam logic [7:0]  CRC = 8'hB6;
    localparam logic [63:0] ID  = {CRC, SER, 8'h3A};

    // [10]=long reset first, [9]=expected selected, [8]=expected od, [7:0]=command
    localparam logic [10:0] VEC [8] = '{
        {1'b1, 1'b1, 1'b0, 8'hCC},
        {1'b1, 1'b1, 1'b1, 8'h3C},
        {1'b0, 1'b1, 1'b1, 8'hCC},
        {1'b0, 1'b0, 1'b1, 8'h12},
        {1'b1, 1'b0, 1'b0, 8'hA5},
        {1'b1, 1'b0, 1'b1, 8'h69},
        {1'b1, 1'b0, 1'b0, 8'hF0},
        {1'b1, 1'b0, 1'b0, 8'h33}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_reset_i = 1'b0;
    logic long_reset_i = 1'b0;
    logic slot_i = 1'b0;
    logic slot_val_i = 1'b0;
    logic tx_en_o, tx_bit_o, selected_o, od_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    romsel_core u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .serial_i     (SER),
        .crc_i        (CRC),
        .bus_reset_i  (bus_reset_i),
        .long_reset_i (long_reset_i),
        .slot_i       (slot_i),
        .slot_val_i   (slot_val_i),
        .tx_en_o      (tx_en_o),
        .tx_bit_o     (tx_bit_o),
        .selected_o   (selected_o),
        .od_o         (od_o)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", req, got, exp);
        end
    endtask

    task automatic do_slot(input logic v, output logic en, output logic b);
        @(negedge clk);
        en = tx_en_o;
        b  = tx_bit_o;
        slot_i = 1'b1;
        slot_val_i = v;
        @(negedge clk);
        slot_i = 1'b0;
        slot_val_i = 1'b0;
    endtask

    task automatic bus_rst(input logic lng);
        @(negedge clk);
        bus_reset_i  = 1'b1;
        long_reset_i = lng;
        @(negedge clk);
        bus_reset_i  = 1'b0;
        long_reset_i = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        logic en, b;
        for (int i = 0; i < 8; i++) do_slot(v[i], en, b);
    endtask

    task automatic send_id(input logic [63:0] v);
        logic en, b;
        for (int i = 0; i < 64; i++) do_slot(v[i], en, b);
    endtask

    initial begin
        #(64'd20 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog got timeout exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic en, b;
        logic [63:0] got;
        int bad;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset outputs", {60'd0, selected_o, od_o, tx_en_o, 1'b0}, 64'd0);
        rst_n = 1'b1;
        // R1: slots before the first bus reset are ignored
        send_byte(8'hCC);
        chk("R1 pre-reset skip ignored", {62'd0, selected_o, tx_en_o}, 64'd0);

        // R2 R6 R9 R10 R7: command table
        for (int k = 0; k < 8; k++) begin
            bus_rst(VEC[k][10]);
            send_byte(VEC[k][7:0]);
            chk($sformatf("R2/R6/R7/R9/R10 cmd %h sel", VEC[k][7:0]), {63'd0, selected_o}, {63'd0, VEC[k][9]});
            chk($sformatf("R9 cmd %h od", VEC[k][7:0]), {63'd0, od_o}, {63'd0, VEC[k][8]});
        end

        // R3: identity stream
        bus_rst(1'b1);
        send_byte(8'h33);
        got = '0; bad = 0;
        for (int i = 0; i < 64; i++) begin
            do_slot(1'b1, en, b);
            got[i] = b;
            if (en !== 1'b1) bad++;
        end
        chk("R3 read stream bits", got, ID);
        chk("R3 family first", {56'd0, got[7:0]}, 64'h3A);
        chk("R3 driven slots", bad, 0);
        chk("R3 selected after stream", {63'd0, selected_o}, 64'd1);

        // R4: full match, then R7 reselect works
        bus_rst(1'b1);
        send_byte(8'h55);
        send_id(ID);
        chk("R4 match selects", {63'd0, selected_o}, 64'd1);
        bus_rst(1'b0);
        send_byte(8'hA5);
        chk("R7 reselect after match", {63'd0, selected_o}, 64'd1);
        // R8: skip clears reselect flag
        bus_rst(1'b0);
        send_byte(8'hCC);
        bus_rst(1'b0);
        send_byte(8'hA5);
        chk("R8 skip clears reselect", {63'd0, selected_o}, 64'd0);

        // R4: late mismatch
        bus_rst(1'b1);
        send_byte(8'h55);
        got = ID;
        got[62] = ~got[62];
        bad = 0;
        for (int i = 0; i < 64; i++) begin
            do_slot(got[i], en, b);
            if (en !== 1'b0) bad++;
        end
        chk("R4 mismatch not selected", {63'd0, selected_o}, 64'd0);
        chk("R4 mismatch silent", bad, 0);
        bus_rst(1'b0);
        send_byte(8'hA5);
        chk("R4 mismatch leaves reselect clear", {63'd0, selected_o}, 64'd0);

        // R5: full search
        bus_rst(1'b1);
        send_byte(8'hF0);
        got = '0; bad = 0;
        for (int i = 0; i < 64; i++) begin
            do_slot(1'b1, en, b);
            got[i] = b;
            if (en !== 1'b1) bad++;
            do_slot(1'b1, en, b);
            if (en !== 1'b1 || b !== ~ID[i]) bad++;
            do_slot(ID[i], en, b);
            if (en !== 1'b0) bad++;
        end
        chk("R5 search true bits", got, ID);
        chk("R5 search triplet shape", bad, 0);
        chk("R5 search selects", {63'd0, selected_o}, 64'd1);
        bus_rst(1'b0);
        send_byte(8'hA5);
        chk("R5 search sets reselect", {63'd0, selected_o}, 64'd1);

        // R5: drop out at bit 5
        bus_rst(1'b1);
        send_byte(8'hF0);
        for (int i = 0; i < 5; i++) begin
            do_slot(1'b1, en, b);
            do_slot(1'b1, en, b);
            do_slot(ID[i], en, b);
        end
        do_slot(1'b1, en, b);
        do_slot(1'b1, en, b);
        do_slot(~ID[5], en, b);
        bad = 0;
        for (int i = 0; i < 6; i++) begin
            do_slot(1'b1, en, b);
            if (en !== 1'b0) bad++;
        end
        chk("R5 dropout silent", bad, 0);
        chk("R5 dropout not selected", {63'd0, selected_o}, 64'd0);

        // R9: fast match keeps od across short reset, long reset clears
        bus_rst(1'b1);
        send_byte(8'h69);
        chk("R9 fast match sets od", {63'd0, od_o}, 64'd1);
        send_id(ID);
        chk("R9 fast match selects", {63'd0, selected_o}, 64'd1);
        bus_rst(1'b0);
        chk("R9 od kept on short reset", {63'd0, od_o}, 64'd1);
        bus_rst(1'b1);
        chk("R9 od cleared on long reset", {63'd0, od_o}, 64'd0);

        // R11: reset in the middle of a stream
        send_byte(8'h33);
        for (int i = 0; i < 10; i++) do_slot(1'b1, en, b);
        bus_rst(1'b0);
        chk("R11 silent after mid-stream reset", {63'd0, tx_en_o}, 64'd0);
        send_byte(8'hCC);
        chk("R11 new command accepted", {63'd0, selected_o}, 64'd1);

        // R11: reset and slot in the same cycle, reset wins
        @(negedge clk);
        bus_reset_i = 1'b1;
        slot_i = 1'b1;
        slot_val_i = 1'b0;
        @(negedge clk);
        bus_reset_i = 1'b0;
        slot_i = 1'b0;
        send_byte(8'hCC);
        chk("R11 reset beats slot", {63'd0, selected_o}, 64'd1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule